// File: doc/BRIEF.md
# Protected page-write buffer engine

This block sits behind a serial bus front end in a small non-volatile memory model. It collects the data bytes of one write transfer into a sixteen-slot page buffer. When the transfer closes with STOP it plays them out onto a 256 x 8 array write port during a self-timed write cycle. The front end has already decoded the bus protocol. It hands over a start-address strobe, a strobe for each data byte, a STOP event and a marker for the protect-register command. A pin input blocks writes to the whole array.

Each byte goes to the 16-byte page that holds the start address. The low four address bits advance and wrap inside that page, so a transfer longer than sixteen bytes overwrites its own oldest bytes and only the last sixteen survive. Two layers of protection filter the writes. The first is a software lock of the lower half of the array, which can be set but never cleared. The second is a hardware pin that covers every address. A blocked byte is dropped, but the busy period still runs its full length. A system can therefore protect none, half or all of the array.

The write-cycle length is a parameter counted in clock cycles. It must be at least the number of buffer slots. The default models about 10 ms at 125 MHz.

Top module: `pgwr_engine`

## Requirements
- R1: During reset and after release with no stimulus, `busy` and `mem_we` stay low. A STOP with no open transfer starts nothing.
- R2: The k-th data byte (counting from 0) of a transfer started at address A is written to address {A[7:4], (A[3:0]+k) mod 16}. The upper four bits never change within a transfer.
- R3: When more than 16 bytes arrive, each slot keeps the latest byte aimed at it. Only the last sixteen bytes are written, and the oldest are replaced first.
- R4: A write cycle starts only on a STOP that closes a data transfer holding at least one byte. A STOP after only a start address raises no `busy` and issues no write.
- R5: `busy` rises on the cycle after the accepted STOP and stays high for exactly WR_CYCLES cycles. Array writes (`mem_we` high) occur only while `busy` is high, at most one per cycle, in ascending slot order.
- R6: A protect-register command closed by STOP while `wp_pin` is low sets the lower-half lock. From then on, writes to addresses 0x00 to 0x7F are dropped and addresses 0x80 to 0xFF are still written. No later command clears the lock.
- R7: When `wp_pin` is high at the STOP, every byte of that transfer is dropped. The busy period still lasts WR_CYCLES cycles.
- R8: A protect-register command closed by STOP while `wp_pin` is high leaves the lock clear, so lower-half writes still succeed afterwards.
- R9: While `busy` is high, the block ignores start-address strobes, data bytes, STOP and protect commands. Such stimulus neither adds writes nor sets the lock.
- R10: A data byte and STOP in the same cycle form one event. The byte is stored, and the write cycle that follows includes it.
- R11: `wp_pin` is sampled at the STOP. A change on it during the write cycle does not alter which bytes of that cycle are written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_ld | input | 1 | Opens a data transfer at `addr_in` |
| addr_in | input | AW | Start address of the transfer |
| prot_cmd | input | 1 | Opens a protect-register command transfer |
| byte_vld | input | 1 | One received data byte on `byte_in` |
| byte_in | input | DW | Data byte |
| stop_evt | input | 1 | STOP seen on the bus |
| wp_pin | input | 1 | High protects the whole array |
| busy | output | 1 | Self-timed write cycle running |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | AW | Array write address |
| mem_wdata | output | DW | Array write data |

## Verification
Two cases make events fall in the same cycle. In the first, the last data byte arrives with STOP. Here the buffer push and the decision to start the write cycle land on one edge, and the commit must already count the byte it is still storing. The bench drives `byte_vld` and `stop_evt` together on one vector and expects that byte in the written set. In the second, the bench drives new address, byte, STOP and protect strobes in the middle of a busy period and moves `wp_pin` just after the STOP. The write port must show exactly the bytes fixed at the STOP. A later lower-half write must still succeed, which shows the lock stayed clear.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  // Kind of transfer currently open on the front end.
  typedef enum logic [1:0] {
    XF_IDLE = 2'd0,
    XF_DATA = 2'd1,
    XF_LOCK = 2'd2
  } xfer_mode_e;
endpackage

// File: rtl/pgwr_page_buf.sv
module pgwr_page_buf #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int SB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          open_i,
  input  logic [AW-1:0] open_addr_i,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          clr_i,
  input  logic [SB-1:0] rd_slot_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_vld_o,
  output logic [AW-SB-1:0] page_o,
  output logic          any_o
);
  localparam int SLOTS = 1 << SB;
  localparam int PW    = AW - SB;

  logic [PW-1:0]    page_q;
  logic [SB-1:0]    ptr_q;
  logic [SLOTS-1:0] vld_q;
  logic [DW-1:0]    data_q [SLOTS];

  // Next slot inside the page: low bits wrap, page bits untouched.
  function automatic logic [SB-1:0] next_slot(input logic [SB-1:0] s);
    return s + SB'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q <= '0;
      ptr_q  <= '0;
      vld_q  <= '0;
    end else if (open_i) begin
      page_q <= open_addr_i[AW-1:SB];
      ptr_q  <= open_addr_i[SB-1:0];
      vld_q  <= '0;
    end else if (clr_i) begin
      vld_q  <= '0;
    end else if (push_i) begin
      vld_q[ptr_q] <= 1'b1;
      ptr_q        <= next_slot(ptr_q);
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_i && !open_i && !clr_i && (ptr_q == SB'(g)))
        data_q[g] <= push_data_i;
    end
  end

  assign rd_data_o = data_q[rd_slot_i];
  assign rd_vld_o  = vld_q[rd_slot_i];
  assign page_o    = page_q;
  assign any_o     = |vld_q;
endmodule

// File: rtl/pgwr_wr_timer.sv
module pgwr_wr_timer #(
  parameter int WR_CYCLES = 16,
  parameter int SB        = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          busy_o,
  output logic          scan_act_o,
  output logic [SB-1:0] scan_slot_o,
  output logic          done_o
);
  localparam int CW = $clog2(WR_CYCLES + 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic [SB:0]   idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(WR_CYCLES - 1);
      idx_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - CW'(1);
      if (!idx_q[SB])  idx_q  <= idx_q + (SB+1)'(1);
    end
  end

  assign busy_o      = busy_q;
  assign scan_act_o  = busy_q && !idx_q[SB];
  assign scan_slot_o = idx_q[SB-1:0];
  assign done_o      = busy_q && (cnt_q == '0);
endmodule

// File: rtl/pgwr_guard.sv
module pgwr_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_go_i,
  input  logic commit_go_i,
  input  logic wp_pin_i,
  input  logic addr_msb_i,
  output logic lock_o,
  output logic wp_held_o,
  output logic blocked_o
);
  logic lock_q;
  logic wp_held_q;

  // Lower half means the top address bit is clear.
  function automatic logic is_blocked(input logic msb, input logic lock,
                                      input logic wp);
    return wp || (lock && !msb);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q    <= 1'b0;
      wp_held_q <= 1'b0;
    end else begin
      if (lock_go_i)   lock_q    <= 1'b1;
      if (commit_go_i) wp_held_q <= wp_pin_i;
    end
  end

  assign lock_o    = lock_q;
  assign wp_held_o = wp_held_q;
  assign blocked_o = is_blocked(addr_msb_i, lock_q, wp_held_q);
endmodule

// File: rtl/pgwr_engine.sv
module pgwr_engine
  import pgwr_pkg::*;
#(
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter int SLOT_BITS = 4,
  parameter int WR_CYCLES = 1250000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_ld,
  input  logic [AW-1:0] addr_in,
  input  logic          prot_cmd,
  input  logic          byte_vld,
  input  logic [DW-1:0] byte_in,
  input  logic          stop_evt,
  input  logic          wp_pin,
  output logic          busy,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  localparam int PW = AW - SLOT_BITS;

  xfer_mode_e mode_q;

  // Named internal events
  logic cmd_go, open_go, push_go, stop_go, commit_go, lock_go;
  logic buf_any, buf_vld, scan_act, wr_done, blocked, lock_q, wp_held;
  logic [SLOT_BITS-1:0] scan_slot;
  logic [PW-1:0]        page;
  logic [DW-1:0]        buf_data;

  function automatic logic [AW-1:0] slot_addr(input logic [PW-1:0] pg,
                                              input logic [SLOT_BITS-1:0] s);
    return {pg, s};
  endfunction

  assign cmd_go    = !busy && prot_cmd;
  assign open_go   = !busy && addr_ld && !prot_cmd;
  assign push_go   = !busy && byte_vld && (mode_q == XF_DATA) && !open_go;
  assign stop_go   = !busy && stop_evt && !open_go && !cmd_go;
  assign commit_go = stop_go && (mode_q == XF_DATA) && (buf_any || push_go);
  assign lock_go   = stop_go && (mode_q == XF_LOCK) && !wp_pin;

  always_ff @(posedge clk) begin
    if (!rst_n)       mode_q <= XF_IDLE;
    else if (cmd_go)  mode_q <= XF_LOCK;
    else if (open_go) mode_q <= XF_DATA;
    else if (stop_go) mode_q <= XF_IDLE;
  end

  pgwr_page_buf #(.AW(AW), .DW(DW), .SB(SLOT_BITS)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .open_i(open_go), .open_addr_i(addr_in),
    .push_i(push_go), .push_data_i(byte_in),
    .clr_i(wr_done),
    .rd_slot_i(scan_slot), .rd_data_o(buf_data), .rd_vld_o(buf_vld),
    .page_o(page), .any_o(buf_any)
  );

  pgwr_wr_timer #(.WR_CYCLES(WR_CYCLES), .SB(SLOT_BITS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start_i(commit_go),
    .busy_o(busy), .scan_act_o(scan_act), .scan_slot_o(scan_slot),
    .done_o(wr_done)
  );

  pgwr_guard u_grd (
    .clk(clk), .rst_n(rst_n),
    .lock_go_i(lock_go), .commit_go_i(commit_go), .wp_pin_i(wp_pin),
    .addr_msb_i(page[PW-1]),
    .lock_o(lock_q), .wp_held_o(wp_held), .blocked_o(blocked)
  );

  assign mem_addr  = slot_addr(page, scan_slot);
  assign mem_wdata = buf_data;
  assign mem_we    = scan_act && buf_vld && !blocked;
endmodule

// File: rtl/pgwr_engine_chk.sv
module pgwr_engine_chk #(
  parameter int AW        = 8,
  parameter int WR_CYCLES = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          stop_evt,
  input logic          wp_pin,
  input logic          lock_q,
  input logic          commit_go
);
  logic [31:0] busy_run;
  logic        wp_at_go;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_run <= '0;
      wp_at_go <= 1'b0;
    end else begin
      busy_run <= busy ? busy_run + 32'd1 : 32'd0;
      if (commit_go) wp_at_go <= wp_pin;
    end
  end

  AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy); // R5
  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run == 32'(WR_CYCLES))); // R5
  AST_GO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    commit_go |=> busy); // R4
  AST_NO_GO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !commit_go) |=> !busy); // R4
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock_q) |-> lock_q); // R6
  AST_LOCK_LOW_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && lock_q) |-> mem_addr[AW-1]); // R6
  AST_WP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && busy) |-> !wp_at_go); // R7
  AST_WP_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && wp_pin && !lock_q) |=> !lock_q); // R8
  AST_BUSY_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !lock_q) |=> !lock_q); // R9
endmodule

bind pgwr_engine pgwr_engine_chk #(.AW(AW), .WR_CYCLES(WR_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_we(mem_we),
  .mem_addr(mem_addr), .stop_evt(stop_evt), .wp_pin(wp_pin),
  .lock_q(lock_q), .commit_go(commit_go)
);

// File: tb/sim_pgwr_engine.sv
module sim_pgwr_engine;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int SB = 4;
  localparam int WR = 24;
  localparam int NV = 17;

  // Vector: [26] wp_flip [25] inject [24] same-cycle [23:16] addr
  //         [15:10] nbytes [9] wp [8] lock cmd [7:0] seed
  localparam logic [26:0] VEC [NV] = '{
    {3'b000, 8'h20, 6'd5,  1'b0, 1'b0, 8'h11},
    {3'b000, 8'h9E, 6'd4,  1'b0, 1'b0, 8'h40},
    {3'b000, 8'h33, 6'd20, 1'b0, 1'b0, 8'h80},
    {3'b000, 8'h50, 6'd0,  1'b0, 1'b0, 8'h00},
    {3'b000, 8'hC0, 6'd3,  1'b1, 1'b0, 8'h21},
    {3'b000, 8'h00, 6'd0,  1'b1, 1'b1, 8'h00},
    {3'b010, 8'h08, 6'd2,  1'b0, 1'b0, 8'h31},
    {3'b000, 8'h00, 6'd1,  1'b0, 1'b0, 8'h05},
    {3'b001, 8'hA0, 6'd3,  1'b0, 1'b0, 8'h61},
    {3'b100, 8'hB0, 6'd2,  1'b0, 1'b0, 8'h71},
    {3'b100, 8'hB4, 6'd2,  1'b1, 1'b0, 8'h72},
    {3'b000, 8'h00, 6'd0,  1'b0, 1'b1, 8'h00},
    {3'b000, 8'h10, 6'd4,  1'b0, 1'b0, 8'h91},
    {3'b000, 8'hF8, 6'd10, 1'b0, 1'b0, 8'hA1},
    {3'b000, 8'h7C, 6'd6,  1'b0, 1'b0, 8'hB1},
    {3'b000, 8'h00, 6'd0,  1'b0, 1'b1, 8'h00},
    {3'b000, 8'h40, 6'd1,  1'b0, 1'b0, 8'hC1}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, addr_ld, prot_cmd, byte_vld, stop_evt, wp_pin;
  logic [AW-1:0] addr_in;
  logic [DW-1:0] byte_in;
  logic busy, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  pgwr_engine #(.AW(AW), .DW(DW), .SLOT_BITS(SB), .WR_CYCLES(WR)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_ld(addr_ld), .addr_in(addr_in),
    .prot_cmd(prot_cmd), .byte_vld(byte_vld), .byte_in(byte_in),
    .stop_evt(stop_evt), .wp_pin(wp_pin), .busy(busy), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] exp_mem [256];
  logic [7:0] act_mem [256];
  bit         lock_m;
  logic [7:0] sd [16];
  bit         sv [16];
  logic [3:0] spage;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic string vtag(input int i);
    case (i)
      0, 1:   return "R2";
      2:      return "R3";
      3:      return "R4";
      4:      return "R7";
      5, 7:   return "R8";
      6:      return "R9";
      8:      return "R10";
      9, 10:  return "R11";
      default: return "R6";
    endcase
  endfunction

  task automatic clear_inputs();
    addr_ld = 0; prot_cmd = 0; byte_vld = 0; stop_evt = 0;
    addr_in = '0; byte_in = '0;
  endtask

  task automatic run_vec(input logic [26:0] v, input string tag);
    logic [7:0] a, seed;
    int n, busy_n, w_n, exp_busy, exp_w, mism;
    bit wp, lk, same, inj, flip;
    logic [7:0] wa;
    flip = v[26]; inj = v[25]; same = v[24]; a = v[23:16];
    n = int'(v[15:10]); wp = v[9]; lk = v[8]; seed = v[7:0];

    @(negedge clk);
    wp_pin = wp;
    if (lk) prot_cmd = 1;
    else begin
      addr_ld = 1; addr_in = a; spage = a[7:4];
      for (int s = 0; s < 16; s++) sv[s] = 0;
    end
    @(negedge clk);
    clear_inputs();
    for (int i = 0; i < n; i++) begin
      byte_vld = 1;
      byte_in  = seed + 8'(i * 13);
      sd[(int'(a[3:0]) + i) % 16] = byte_in;
      sv[(int'(a[3:0]) + i) % 16] = 1;
      if (same && i == n - 1) stop_evt = 1;
      @(negedge clk);
    end
    byte_vld = 0;
    if (!same || n == 0) begin
      stop_evt = 1;
      @(negedge clk);
    end
    stop_evt = 0;

    exp_busy = 0; exp_w = 0;
    if (lk) begin
      if (!wp) lock_m = 1;
    end else if (n > 0) begin
      exp_busy = WR;
      for (int s = 0; s < 16; s++) begin
        if (sv[s]) begin
          wa = {spage, 4'(s)};
          if (!(wp || (lock_m && wa < 8'h80))) begin
            exp_mem[wa] = sd[s];
            exp_w++;
          end
        end
      end
    end

    busy_n = 0; w_n = 0;
    for (int k = 0; k < WR + 4; k++) begin
      if (busy === 1'b1) busy_n++;
      if (mem_we === 1'b1) begin
        act_mem[mem_addr] = mem_wdata;
        w_n++;
      end
      addr_ld  = inj && (k == 2);
      addr_in  = '0;
      byte_vld = inj && (k == 3);
      byte_in  = 8'hEE;
      stop_evt = inj && (k == 4 || k == 6);
      prot_cmd = inj && (k == 5);
      if (flip && k == 1) wp_pin = !wp;
      @(negedge clk);
    end
    clear_inputs();

    chk(busy_n == exp_busy, (!lk && n > 0) ? "R5" : tag, "busy cycles",
        busy_n, exp_busy);
    chk(w_n == exp_w, tag, "write strobes", w_n, exp_w);
    mism = 0;
    for (int i = 0; i < 256; i++) if (act_mem[i] !== exp_mem[i]) mism++;
    chk(mism == 0, tag, "array mismatches", mism, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R5 watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int bn;
    for (int i = 0; i < 256; i++) begin exp_mem[i] = 8'h00; act_mem[i] = 8'h00; end
    lock_m = 0;
    rst_n = 0; wp_pin = 0;
    clear_inputs();
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R1", "busy in reset", int'(busy), 0);
    chk(mem_we === 1'b0, "R1", "mem_we in reset", int'(mem_we), 0);
    rst_n = 1;
    @(negedge clk);
    stop_evt = 1;
    @(negedge clk);
    stop_evt = 0;
    bn = 0;
    for (int k = 0; k < 6; k++) begin
      if (busy !== 1'b0 || mem_we !== 1'b0) bn++;
      @(negedge clk);
    end
    chk(bn == 0, "R1", "activity after bare STOP", bn, 0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], vtag(i));

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule